// File: doc/BRIEF.md
# I2C SCL High/Low Period Generator

This block produces the clock waveform for an I2C bus master. It keeps three pairs of high and low cycle counts, one pair each for standard, fast and high-speed operation. A mode input picks the pair to use. The block drives an open-drain pull-down enable for SCL and watches the line through a synchronizer, so a slave that holds SCL low stretches the clock. It also emits single-cycle strobes on every falling and rising SCL edge that it causes, for a bit-level engine to use.

The programmed counts are not the raw period. The low phase starts counting in the cycle the pull-down is applied and lasts one cycle more than its count. The high phase carries a fixed overhead of eight cycles on top of its count. Part of that overhead is the synchronizer latency and part is the counter's turnaround. A count below six is raised to six. Standard-mode counts are normally chosen for a 4.0 µs high and 4.7 µs low time, and fast-mode counts for 0.6 µs high and 1.3 µs low. An instance built without high-speed support runs the fast pair whenever high-speed is requested.

Top module: `scl_period_gen`

## Requirements
- R1: While rst_ni is low, and in the cycle after it is released, scl_drive_o, scl_rise_o and scl_fall_o are all 0.
- R2: When enable_i is sampled high at a clock edge while the generator is idle, scl_drive_o becomes 1 and scl_fall_o pulses in the cycle that follows that edge.
- R3: Each low phase keeps scl_drive_o at 1 for exactly (effective low count + 1) cycles. The count is taken from the selected pair when the phase starts.
- R4: If scl_i goes high in the first cycle after release, the release lasts exactly (effective high count + 8) cycles. That is the time from the scl_rise_o pulse to the next scl_fall_o pulse.
- R5: For every cycle that scl_i is still held low after the release, the high phase lasts one cycle longer, because counting only starts once the synchronized line reads high.
- R6: mode_i selects the count pair: 0 = standard, 1 = fast, 2 = high-speed, 3 = fast.
- R7: When HS_SUPPORT is 0, mode 2 uses the fast pair.
- R8: A count below 6 is used as 6, so the shortest low phase is 7 cycles and the shortest unstretched high phase is 14 cycles.
- R9: scl_fall_o is a one-cycle pulse in the first cycle of scl_drive_o = 1. scl_rise_o is a one-cycle pulse in the first cycle of release after a low phase. The two never pulse together.
- R10: When enable_i is sampled low, scl_drive_o is 0 in the next cycle, and no strobe is produced while enable_i stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run the generator |
| mode_i | input | 2 | Count pair select (0 std, 1 fast, 2 high-speed, 3 fast) |
| std_hcnt_i | input | CNT_W | Standard-mode high count |
| std_lcnt_i | input | CNT_W | Standard-mode low count |
| fast_hcnt_i | input | CNT_W | Fast-mode high count |
| fast_lcnt_i | input | CNT_W | Fast-mode low count |
| hs_hcnt_i | input | CNT_W | High-speed high count |
| hs_lcnt_i | input | CNT_W | High-speed low count |
| scl_i | input | 1 | Sampled SCL line level |
| scl_drive_o | output | 1 | 1 = pull SCL low |
| scl_fall_o | output | 1 | Strobe: pull-down applied this cycle |
| scl_rise_o | output | 1 | Strobe: pull-down released this cycle |

## Verification
Every result is timed as a gap in cycles from the previous strobe. The first falling strobe comes one cycle after the cycle in which enable is raised. A rising strobe comes (low count + 1) cycles after a falling one. The next falling strobe comes (high count + 8 + stretch) cycles after a rising one, and the pull-down disappears one cycle after enable drops. The driver queues each expected strobe with its kind and gap. The monitor samples at the falling clock edge, stamps every strobe with the cycle counter and compares it with the head of the queue, so any early, late, missing or extra strobe is reported. A second instance built without high-speed support runs in parallel to check the fallback intervals.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    MODE_STD  = 2'd0,
    MODE_FAST = 2'd1,
    MODE_HS   = 2'd2,
    MODE_ALT  = 2'd3
  } scl_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOW,
    PH_WAIT,
    PH_HIGH
  } scl_phase_e;
endpackage

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= 1'b1;
        else         sr_q <= line_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '1;
        else         sr_q <= {sr_q[STAGES-2:0], line_i};
      end
    end
  endgenerate

  assign line_o = sr_q[STAGES-1];
endmodule

// File: rtl/scl_cnt_select.sv
module scl_cnt_select
  import scl_gen_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int MIN_CNT    = 6,
  parameter bit HS_SUPPORT = 1'b1
) (
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] std_hcnt_i,
  input  logic [CNT_W-1:0] std_lcnt_i,
  input  logic [CNT_W-1:0] fast_hcnt_i,
  input  logic [CNT_W-1:0] fast_lcnt_i,
  input  logic [CNT_W-1:0] hs_hcnt_i,
  input  logic [CNT_W-1:0] hs_lcnt_i,
  output logic [CNT_W-1:0] hcnt_o,
  output logic [CNT_W-1:0] lcnt_o
);
  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_CNT);

  logic [CNT_W-1:0] sel_h, sel_l;

  generate
    if (HS_SUPPORT) begin : g_hs
      always_comb begin
        unique case (mode_i)
          MODE_STD: begin sel_h = std_hcnt_i;  sel_l = std_lcnt_i;  end
          MODE_HS:  begin sel_h = hs_hcnt_i;   sel_l = hs_lcnt_i;   end
          default:  begin sel_h = fast_hcnt_i; sel_l = fast_lcnt_i; end
        endcase
      end
    end else begin : g_no_hs
      logic hs_unused;
      assign hs_unused = ^{hs_hcnt_i, hs_lcnt_i};
      always_comb begin
        if (mode_i == MODE_STD) begin
          sel_h = std_hcnt_i;
          sel_l = std_lcnt_i;
        end else begin
          // high-speed request falls back to the fast pair
          sel_h = fast_hcnt_i;
          sel_l = fast_lcnt_i;
        end
      end
    end
  endgenerate

  assign hcnt_o = (sel_h < FLOOR) ? FLOOR : sel_h;
  assign lcnt_o = (sel_l < FLOOR) ? FLOOR : sel_l;
endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_gen_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int LOW_ADD  = 0,
  parameter int HIGH_ADD = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             line_hi_i,
  input  logic [CNT_W-1:0] hcnt_i,
  input  logic [CNT_W-1:0] lcnt_i,
  output logic             drive_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam int TW = CNT_W + 4;

  scl_phase_e       phase_q;
  logic [TW-1:0]    cnt_q;
  logic [TW-1:0]    low_load, high_load;
  logic             cnt_zero;

  assign low_load  = TW'(lcnt_i) + TW'(LOW_ADD);
  assign high_load = TW'(hcnt_i) + TW'(HIGH_ADD);
  assign cnt_zero  = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      drive_o <= 1'b0;
      rise_o  <= 1'b0;
      fall_o  <= 1'b0;
    end else begin
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      if (!enable_i) begin
        phase_q <= PH_IDLE;
        drive_o <= 1'b0;
        cnt_q   <= '0;
      end else begin
        unique case (phase_q)
          PH_IDLE: begin
            phase_q <= PH_LOW;
            drive_o <= 1'b1;
            fall_o  <= 1'b1;
            cnt_q   <= low_load;
          end
          PH_LOW: begin
            if (cnt_zero) begin
              phase_q <= PH_WAIT;
              drive_o <= 1'b0;
              rise_o  <= 1'b1;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          PH_WAIT: begin
            // slave stretching holds us here
            if (line_hi_i) begin
              phase_q <= PH_HIGH;
              cnt_q   <= high_load;
            end
          end
          PH_HIGH: begin
            if (cnt_zero) begin
              phase_q <= PH_LOW;
              drive_o <= 1'b1;
              fall_o  <= 1'b1;
              cnt_q   <= low_load;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen #(
  parameter int CNT_W       = 16,
  parameter int MIN_CNT     = 6,
  parameter int LOW_OVH     = 1,
  parameter int HIGH_OVH    = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit HS_SUPPORT  = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] std_hcnt_i,
  input  logic [CNT_W-1:0] std_lcnt_i,
  input  logic [CNT_W-1:0] fast_hcnt_i,
  input  logic [CNT_W-1:0] fast_lcnt_i,
  input  logic [CNT_W-1:0] hs_hcnt_i,
  input  logic [CNT_W-1:0] hs_lcnt_i,
  input  logic             scl_i,
  output logic             scl_drive_o,
  output logic             scl_fall_o,
  output logic             scl_rise_o
);
  // counter turnaround and synchronizer latency absorb part of each overhead
  localparam int LOW_ADD  = LOW_OVH - 1;
  localparam int HIGH_ADD = HIGH_OVH - SYNC_STAGES - 2;

  logic             line_hi;
  logic [CNT_W-1:0] hcnt_eff, lcnt_eff;

  scl_line_sync #(
    .STAGES(SYNC_STAGES)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .line_i(scl_i),
    .line_o(line_hi)
  );

  scl_cnt_select #(
    .CNT_W     (CNT_W),
    .MIN_CNT   (MIN_CNT),
    .HS_SUPPORT(HS_SUPPORT)
  ) i_select (
    .mode_i     (mode_i),
    .std_hcnt_i (std_hcnt_i),
    .std_lcnt_i (std_lcnt_i),
    .fast_hcnt_i(fast_hcnt_i),
    .fast_lcnt_i(fast_lcnt_i),
    .hs_hcnt_i  (hs_hcnt_i),
    .hs_lcnt_i  (hs_lcnt_i),
    .hcnt_o     (hcnt_eff),
    .lcnt_o     (lcnt_eff)
  );

  scl_phase_ctrl #(
    .CNT_W   (CNT_W),
    .LOW_ADD (LOW_ADD),
    .HIGH_ADD(HIGH_ADD)
  ) i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .line_hi_i(line_hi),
    .hcnt_i   (hcnt_eff),
    .lcnt_i   (lcnt_eff),
    .drive_o  (scl_drive_o),
    .rise_o   (scl_rise_o),
    .fall_o   (scl_fall_o)
  );
endmodule

// File: rtl/scl_period_gen_chk.sv
module scl_period_gen_chk #(
  parameter int MIN_CNT  = 6,
  parameter int LOW_OVH  = 1,
  parameter int HIGH_OVH = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic enable_i,
  input logic scl_drive_o,
  input logic scl_fall_o,
  input logic scl_rise_o
);
  int   lo_run_q, hi_run_q;
  logic hi_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_run_q   <= 0;
      hi_run_q   <= 0;
      hi_valid_q <= 1'b0;
    end else begin
      lo_run_q   <= scl_drive_o ? lo_run_q + 1 : 0;
      hi_run_q   <= scl_rise_o ? 1 : (!scl_drive_o ? hi_run_q + 1 : 0);
      hi_valid_q <= !enable_i ? 1'b0 : (scl_rise_o ? 1'b1 : hi_valid_q);
    end
  end

  AST_FALL_AT_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_fall_o |-> scl_drive_o && !$past(scl_drive_o)); // R9
  AST_RISE_AT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_rise_o |-> !scl_drive_o && $past(scl_drive_o)); // R9
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({scl_rise_o, scl_fall_o})); // R9
  AST_DISABLE_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !scl_drive_o && !scl_rise_o && !scl_fall_o); // R10
  AST_LOW_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_rise_o |-> lo_run_q >= MIN_CNT + LOW_OVH); // R8
  AST_HIGH_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_fall_o && hi_valid_q |-> hi_run_q >= MIN_CNT + HIGH_OVH); // R8
endmodule

bind scl_period_gen scl_period_gen_chk #(
  .MIN_CNT (MIN_CNT),
  .LOW_OVH (LOW_OVH),
  .HIGH_OVH(HIGH_OVH)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enable_i   (enable_i),
  .scl_drive_o(scl_drive_o),
  .scl_fall_o (scl_fall_o),
  .scl_rise_o (scl_rise_o)
);

// File: tb/test_scl_period_gen.sv
module test_scl_period_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [15:0] sh = 16'd0, sl = 16'd0, fh = 16'd0, fl = 16'd0, hh = 16'd0, hl = 16'd0;
  logic        scl_line = 1'b1;
  logic        drive_o, fall_o, rise_o;
  logic        nh_drive, nh_fall, nh_rise, nh_line;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_stamp = 0;
  int stretch_amt = 0;
  int hold_left = 0;
  int nh_fall_t = -1, nh_rise_t = -1, nh_low = -1, nh_high = -1;
  bit done = 1'b0;

  typedef struct {
    bit    rise;
    int    gap;
    string req;
  } ev_t;
  ev_t sb_q[$];

  always #4 clk = ~clk;

  scl_period_gen i_scl_period_gen (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .mode_i(mode),
    .std_hcnt_i(sh), .std_lcnt_i(sl), .fast_hcnt_i(fh), .fast_lcnt_i(fl),
    .hs_hcnt_i(hh), .hs_lcnt_i(hl), .scl_i(scl_line),
    .scl_drive_o(drive_o), .scl_fall_o(fall_o), .scl_rise_o(rise_o)
  );

  assign nh_line = !nh_drive;
  scl_period_gen #(.HS_SUPPORT(1'b0)) i_scl_period_gen_nohs (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .mode_i(mode),
    .std_hcnt_i(sh), .std_lcnt_i(sl), .fast_hcnt_i(fh), .fast_lcnt_i(fl),
    .hs_hcnt_i(hh), .hs_lcnt_i(hl), .scl_i(nh_line),
    .scl_drive_o(nh_drive), .scl_fall_o(nh_fall), .scl_rise_o(nh_rise)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // bus model: slave may hold the line low after release
  always @(negedge clk) begin
    if (drive_o) begin
      hold_left = stretch_amt;
      scl_line  = 1'b0;
    end else if (hold_left > 0) begin
      hold_left--;
      scl_line = 1'b0;
    end else begin
      scl_line = 1'b1;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (rise_o || fall_o)) begin
      if (sb_q.size() == 0) begin
        chk("R10 unexpected strobe", 1, 0);
      end else begin
        ev_t ev;
        ev = sb_q.pop_front();
        chk({ev.req, " kind"}, int'(rise_o), int'(ev.rise));
        chk({ev.req, " gap"}, cyc - last_stamp, ev.gap);
        chk("R9 drive at strobe", int'(drive_o), rise_o ? 0 : 1);
      end
      if (rise_o && fall_o) chk("R9 both strobes", 1, 0);
      last_stamp = cyc;
    end
    if (rst_n && nh_fall) begin
      if (nh_rise_t >= 0) nh_high = cyc - nh_rise_t;
      nh_fall_t = cyc;
    end
    if (rst_n && nh_rise) begin
      if (nh_fall_t >= 0) nh_low = cyc - nh_fall_t;
      nh_rise_t = cyc;
    end
  end

  task automatic run_case(input logic [1:0] m, input int heff, input int leff,
                          input int stretch, input int periods, input string tag);
    @(negedge clk);
    mode = m;
    stretch_amt = stretch;
    sb_q.push_back('{1'b0, 1, {"R2 start ", tag}});
    for (int p = 0; p < periods; p++) begin
      sb_q.push_back('{1'b1, leff + 1, {"R3 low ", tag}});
      sb_q.push_back('{1'b0, heff + 8 + stretch,
                       (stretch > 0) ? {"R5 stretch ", tag} : {"R4 high ", tag}});
    end
    last_stamp = cyc;
    enable = 1'b1;
    wait (sb_q.size() == 0);
    enable = 1'b0;
    @(negedge clk);
    chk({"R10 released ", tag}, int'(drive_o), 0);
    repeat (3) @(negedge clk);
    stretch_amt = 0;
  endtask

  initial begin
    sh = 16'd20; sl = 16'd30;
    fh = 16'd9;  fl = 16'd11;
    hh = 16'd6;  hl = 16'd7;
    repeat (2) @(negedge clk);
    chk("R1 drive in reset", int'(drive_o), 0);
    chk("R1 fall in reset", int'(fall_o), 0);
    chk("R1 rise in reset", int'(rise_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 drive after reset", int'(drive_o), 0);
    chk("R1 strobes after reset", int'(rise_o | fall_o), 0);

    run_case(2'd0, 20, 30, 0, 3, "R6 std");
    run_case(2'd1, 9, 11, 0, 3, "R6 fast");
    nh_fall_t = -1; nh_rise_t = -1; nh_low = -1; nh_high = -1;
    run_case(2'd2, 6, 7, 0, 4, "R6 hs");
    chk("R7 fallback low", nh_low, 12);
    chk("R7 fallback high", nh_high, 17);
    run_case(2'd3, 9, 11, 0, 2, "R6 mode3");
    run_case(2'd1, 9, 11, 5, 2, "R5");

    sh = 16'd0; sl = 16'd5;
    run_case(2'd0, 6, 6, 0, 2, "R8 clamp");
    sh = 16'd6; sl = 16'd2;
    run_case(2'd0, 6, 6, 3, 2, "R8 clamp stretch");

    // disable in the middle of a low phase
    sh = 16'd20; sl = 16'd30;
    @(negedge clk);
    mode = 2'd0;
    sb_q.push_back('{1'b0, 1, "R2 start mid"});
    last_stamp = cyc;
    enable = 1'b1;
    wait (sb_q.size() == 0);
    repeat (3) @(negedge clk);
    chk("R10 still low before drop", int'(drive_o), 1);
    enable = 1'b0;
    @(negedge clk);
    chk("R10 released after drop", int'(drive_o), 0);
    repeat (40) @(negedge clk);
    chk("R10 stays released", int'(drive_o), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule